// File: doc/BRIEF.md
# Multiprocessor Slot Interrupt Router

This block collects level-sensitive interrupt requests from up to 32 device slots and turns them into one interrupt line per CPU. A global per-slot enable word gates the live request levels. Each CPU then applies its own routing word to the gated set. A CPU's line is raised when any request survives both masks, or when that CPU's software-set interprocessor flag is on.

Software reaches the controller through a single-beat 32-bit register port that carries the identifier of the CPU making the access. Besides the interrupt state, the controller returns several values:

- the installed memory size and the mask of CPUs present, both taken from inputs;
- a one-hot identity word for the requesting CPU.

It also holds a run-enable register that releases individual CPUs, and a power-off request that latches once set. An access handshake state machine has two states. IDLE raises `req_ready`. On IDLE with `req_valid` it takes the transition ACCEPT into ACK, and the register action happens at that edge. ACK raises `resp_ack` with the read data. From ACK it takes the transition RETIRE back to IDLE unconditionally.

Top module: `mpic_top`

## Requirements
- R1: After reset the global enable word is all ones, every routing word and interprocessor flag is zero, `cpu_run` holds only bit BOOT_CPU (bit 0 by default), `power_off` is 0 and every `cpu_irq` is 0.
- R2: A request is taken only when `req_ready` is 1 (IDLE). `resp_ack` is 1 for exactly the one cycle after acceptance and carries the read data in `resp_rdata`. `req_ready` is 0 during that cycle, and a request presented then is not taken.
- R3: A read of offset 0x204 returns the live slot request levels, with bit n standing for slot n. Reading it does not clear any bit.
- R4: The word at offset 0x20C is read/write with one bit per slot. A slot whose bit is 0 cannot raise any `cpu_irq`.
- R5: The routing word of CPU k is at offset 0x400 + k*0x400 + 0x000. `cpu_irq[k]` equals OR(pending & global enable & routing word k) OR flag k, registered, so it reflects its inputs one clock later.
- R6: The interprocessor flag of CPU k is at offset 0x400 + k*0x400 + 0x004. A write sets it to bit 0 of the data (1 sets, 0 clears), and a read returns it in bit 0.
- R7: A read of offset 0x218 returns a word with only bit `req_cpu` set.
- R8: A write to offset 0x214 loads `cpu_run` with the low NCPU data bits, and a read returns that value.
- R9: Writing 0 to offset 0x208 sets `power_off`, which stays 1 until reset. Nonzero writes there have no effect.
- R10: A read of offset 0x200 returns `mem_size`, and a read of offset 0x210 returns `cpu_present`.
- R11: Unmapped offsets read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_irq | input | NSLOT | Live level request of each slot |
| cpu_present | input | NCPU | Mask of installed CPUs |
| mem_size | input | 32 | Installed memory size in bytes |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CW | Hardware number of the requesting CPU |
| req_addr | input | AW | Byte offset within controller space |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Controller can take a request (IDLE) |
| resp_ack | output | 1 | Access completed; read data valid |
| resp_rdata | output | 32 | Read data |
| cpu_irq | output | NCPU | Interrupt line of each CPU |
| cpu_run | output | NCPU | Run enable of each CPU |
| power_off | output | 1 | Latched power-off request |

## Verification
Read data arrives in the cycle after the accepting edge. The bench's monitor samples it on the falling edge of the `resp_ack` cycle and pops the expected word that the driver queued before the request. Register writes take effect at the accepting edge, but `cpu_irq` is registered on top of them, so it settles one further edge later. The same applies to a change on `slot_irq`. Every interrupt-line check therefore waits for a full edge beyond the stimulus and samples on a falling edge. `cpu_run` and `power_off` follow the write at the accepting edge itself.

// File: rtl/mpic_pkg.sv
`timescale 1ns/1ps
package mpic_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } acc_state_t;

    localparam logic [9:0] OFS_MEMSZ  = 10'h200;
    localparam logic [9:0] OFS_PEND   = 10'h204;
    localparam logic [9:0] OFS_POWER  = 10'h208;
    localparam logic [9:0] OFS_GEN    = 10'h20C;
    localparam logic [9:0] OFS_PRES   = 10'h210;
    localparam logic [9:0] OFS_RUN    = 10'h214;
    localparam logic [9:0] OFS_SELF   = 10'h218;
    localparam logic [9:0] OFS_ROUTE  = 10'h000;
    localparam logic [9:0] OFS_IPI    = 10'h004;
endpackage

// File: rtl/mpic_access_fsm.sv
`timescale 1ns/1ps
module mpic_access_fsm
    import mpic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic ready,
    output logic accept,
    output logic ack
);
    acc_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_ACK;
            ST_ACK:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready  = (state_q == ST_IDLE);
        ack    = (state_q == ST_ACK);
        accept = (state_q == ST_IDLE) && req_valid;
    end
endmodule

// File: rtl/mpic_cpu_slice.sv
`timescale 1ns/1ps
module mpic_cpu_slice #(
    parameter int NSLOT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_route,
    input  logic             wr_ipi,
    input  logic [NSLOT-1:0] wdata_route,
    input  logic             wdata_ipi,
    input  logic [NSLOT-1:0] gated_pend,
    output logic [NSLOT-1:0] route,
    output logic             ipi,
    output logic             irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route <= '0;
            ipi   <= 1'b0;
            irq   <= 1'b0;
        end else begin
            if (wr_route) route <= wdata_route;
            if (wr_ipi)   ipi   <= wdata_ipi;
            irq <= (|(gated_pend & route)) | ipi;
        end
    end
endmodule

// File: rtl/mpic_top.sv
`timescale 1ns/1ps
module mpic_top
    import mpic_pkg::*;
#(
    parameter int NSLOT    = 32,
    parameter int NCPU     = 4,
    parameter int BOOT_CPU = 0,
    parameter int AW       = 16,
    parameter int CW       = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] slot_irq,
    input  logic [NCPU-1:0]  cpu_present,
    input  logic [31:0]      mem_size,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [CW-1:0]    req_cpu,
    input  logic [AW-1:0]    req_addr,
    input  logic [31:0]      req_wdata,
    output logic             req_ready,
    output logic             resp_ack,
    output logic [31:0]      resp_rdata,
    output logic [NCPU-1:0]  cpu_irq,
    output logic [NCPU-1:0]  cpu_run,
    output logic             power_off
);
    localparam int RW = AW - 10;
    localparam logic [NCPU-1:0] RUN_RST = NCPU'(1) << BOOT_CPU;

    logic accept, wr_acc, rd_acc;
    logic [RW-1:0] region;
    logic [9:0]    low;
    logic          ctl_hit;
    logic [NCPU-1:0] cpu_hit;

    logic [NSLOT-1:0] gen_q;
    logic [NCPU-1:0]  run_q;
    logic             off_q;
    logic [31:0]      rdata_q, rd_mux;
    logic [NSLOT-1:0] gated_pend;
    logic [NCPU-1:0][NSLOT-1:0] route_all;
    logic [NCPU-1:0]  ipi_all;

    mpic_access_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .ready    (req_ready),
        .accept   (accept),
        .ack      (resp_ack)
    );

    assign wr_acc     = accept & req_write;
    assign rd_acc     = accept & ~req_write;
    assign region     = req_addr[AW-1:10];
    assign low        = req_addr[9:0];
    assign ctl_hit    = (region == '0);
    assign gated_pend = slot_irq & gen_q;

    for (genvar k = 0; k < NCPU; k++) begin : g_cpu
        assign cpu_hit[k] = (region == RW'(k + 1));
        mpic_cpu_slice #(.NSLOT(NSLOT)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_route   (wr_acc && cpu_hit[k] && (low == OFS_ROUTE)),
            .wr_ipi     (wr_acc && cpu_hit[k] && (low == OFS_IPI)),
            .wdata_route(req_wdata[NSLOT-1:0]),
            .wdata_ipi  (req_wdata[0]),
            .gated_pend (gated_pend),
            .route      (route_all[k]),
            .ipi        (ipi_all[k]),
            .irq        (cpu_irq[k])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '1;
            run_q <= RUN_RST;
            off_q <= 1'b0;
        end else if (wr_acc && ctl_hit) begin
            if (low == OFS_GEN)                       gen_q <= req_wdata[NSLOT-1:0];
            if (low == OFS_RUN)                       run_q <= req_wdata[NCPU-1:0];
            if ((low == OFS_POWER) && (req_wdata == '0)) off_q <= 1'b1;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (ctl_hit) begin
            unique case (low)
                OFS_MEMSZ: rd_mux = mem_size;
                OFS_PEND:  rd_mux[NSLOT-1:0] = slot_irq;
                OFS_GEN:   rd_mux[NSLOT-1:0] = gen_q;
                OFS_PRES:  rd_mux[NCPU-1:0]  = cpu_present;
                OFS_RUN:   rd_mux[NCPU-1:0]  = run_q;
                OFS_SELF:  rd_mux[req_cpu]   = 1'b1;
                default:   rd_mux = '0;
            endcase
        end
        for (int k = 0; k < NCPU; k++) begin
            if (cpu_hit[k]) begin
                if (low == OFS_ROUTE) rd_mux[NSLOT-1:0] = route_all[k];
                if (low == OFS_IPI)   rd_mux[0]         = ipi_all[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_acc) rdata_q <= rd_mux;
        else if (wr_acc) rdata_q <= '0;
    end

    assign resp_rdata = rdata_q;
    assign cpu_run    = run_q;
    assign power_off  = off_q;
endmodule

// File: rtl/mpic_sva.sv
`timescale 1ns/1ps
module mpic_sva #(
    parameter int NSLOT = 32,
    parameter int NCPU  = 4,
    parameter int AW    = 16,
    parameter int CW    = 2
) (
    input logic clk,
    input logic rst_n,
    input logic [NSLOT-1:0] slot_irq,
    input logic req_valid,
    input logic req_ready,
    input logic req_write,
    input logic [CW-1:0] req_cpu,
    input logic [AW-1:0] req_addr,
    input logic [31:0] req_wdata,
    input logic resp_ack,
    input logic [31:0] resp_rdata,
    input logic [NCPU-1:0] cpu_irq,
    input logic power_off,
    input logic [NSLOT-1:0] gen_q,
    input logic [NCPU-1:0][NSLOT-1:0] route_all,
    input logic [NCPU-1:0] ipi_all
);
    a_r2_ack_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_ack);

    a_r2_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ack |=> !resp_ack);

    a_r2_not_ready_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ack |-> !req_ready);

    a_r7_self_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && req_addr == AW'(16'h0218))
        |=> (resp_rdata == (32'(1) << $past(req_cpu))));

    a_r9_power_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        power_off |=> power_off);

    a_r9_power_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && req_addr == AW'(16'h0208)
         && req_wdata == 32'd0) |=> power_off);

    for (genvar k = 0; k < NCPU; k++) begin : g_chk
        a_r5_irq_equation: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[k] == $past((|(slot_irq & gen_q & route_all[k])) | ipi_all[k]));
    end
endmodule

bind mpic_top mpic_sva #(.NSLOT(NSLOT), .NCPU(NCPU), .AW(AW), .CW(CW)) u_sva (
    .clk(clk), .rst_n(rst_n), .slot_irq(slot_irq), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_cpu(req_cpu),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_ack(resp_ack),
    .resp_rdata(resp_rdata), .cpu_irq(cpu_irq), .power_off(power_off),
    .gen_q(gen_q), .route_all(route_all), .ipi_all(ipi_all)
);

// File: tb/mpic_top_tb_top.sv
`timescale 1ns/1ps
module mpic_top_tb_top;
    localparam int NSLOT = 32;
    localparam int NCPU  = 4;
    localparam int AW    = 16;
    localparam int CW    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSLOT-1:0] slot_irq = '0;
    logic [NCPU-1:0]  cpu_present = 4'b1111;
    logic [31:0]      mem_size = 32'h0010_0000;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [CW-1:0] req_cpu = '0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic req_ready, resp_ack, power_off;
    logic [31:0] resp_rdata;
    logic [NCPU-1:0] cpu_irq, cpu_run;

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          rd_q[$];

    always #2 clk = ~clk;

    mpic_top #(.NSLOT(NSLOT), .NCPU(NCPU), .AW(AW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .slot_irq(slot_irq), .cpu_present(cpu_present),
        .mem_size(mem_size), .req_valid(req_valid), .req_write(req_write),
        .req_cpu(req_cpu), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .resp_ack(resp_ack), .resp_rdata(resp_rdata),
        .cpu_irq(cpu_irq), .cpu_run(cpu_run), .power_off(power_off)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every acknowledged access.
    always @(negedge clk) begin
        if (rst_n && resp_ack) begin
            if (rd_q.size() == 0) begin
                chk("R2 unexpected ack", 32'd1, 32'd0);
            end else begin
                automatic bit    is_rd = rd_q.pop_front();
                automatic string t     = tag_q.pop_front();
                automatic logic [31:0] e = exp_q.pop_front();
                chk({t, " ready-in-ack"}, {31'd0, req_ready}, 32'd0);
                if (is_rd) chk(t, resp_rdata, e);
            end
        end
    end

    // Driver: called at a falling edge, returns at a falling edge.
    task automatic access(input bit wr, input int cpu, input int addr,
                          input logic [31:0] wd, input logic [31:0] exp, input string tag);
        rd_q.push_back(!wr);
        tag_q.push_back(tag);
        exp_q.push_back(exp);
        req_valid = 1'b1;
        req_write = wr;
        req_cpu   = CW'(cpu);
        req_addr  = AW'(addr);
        req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cpu_irq", 32'(cpu_irq), 32'd0);
        chk("R1 cpu_run", 32'(cpu_run), 32'd1);
        chk("R1 power_off", 32'(power_off), 32'd0);
        chk("R2 ready idle", 32'(req_ready), 32'd1);
        access(0, 0, 'h20C, 0, 32'hFFFF_FFFF, "R1 global enable");
        access(0, 0, 'h800, 0, 32'd0, "R1 route cpu1");
        access(0, 0, 'hC04, 0, 32'd0, "R1 ipi cpu2");
        // R10 constants
        access(0, 1, 'h200, 0, 32'h0010_0000, "R10 mem size");
        access(0, 1, 'h210, 0, 32'h0000_000F, "R10 present");
        // R7 self identity
        access(0, 2, 'h218, 0, 32'h4, "R7 self cpu2");
        access(0, 0, 'h218, 0, 32'h1, "R7 self cpu0");
        access(0, 3, 'h218, 0, 32'h8, "R7 self cpu3");
        // R3 live pending, not cleared by read
        slot_irq = 32'h0000_0104;
        settle();
        access(0, 0, 'h204, 0, 32'h0000_0104, "R3 pending first");
        access(0, 0, 'h204, 0, 32'h0000_0104, "R3 pending second");
        chk("R5 no route no irq", 32'(cpu_irq), 32'd0);
        // R5 route slot 2 to cpu1 only
        access(1, 0, 'h800, 32'h4, 0, "R5 write route");
        settle();
        chk("R5 single cpu routing", 32'(cpu_irq), 32'b0010);
        access(0, 0, 'h800, 0, 32'h4, "R5 route readback");
        // R4 global mask
        access(1, 0, 'h20C, 32'hFFFF_FFFB, 0, "R4 mask slot2");
        settle();
        chk("R4 masked slot", 32'(cpu_irq), 32'd0);
        access(0, 0, 'h20C, 0, 32'hFFFF_FFFB, "R4 readback");
        access(1, 0, 'h20C, 32'hFFFF_FFFF, 0, "R4 unmask");
        settle();
        chk("R4 unmasked slot", 32'(cpu_irq), 32'b0010);
        // R6 interprocessor flag while the level request stays held
        access(1, 0, 'h1004, 32'h1, 0, "R6 set ipi3");
        settle();
        chk("R6 ipi3 set", 32'(cpu_irq), 32'b1010);
        access(0, 0, 'h1004, 0, 32'h1, "R6 ipi3 readback");
        access(1, 0, 'h1004, 32'h0, 0, "R6 clear ipi3");
        settle();
        chk("R6 ipi3 cleared", 32'(cpu_irq), 32'b0010);
        access(1, 0, 'h804, 32'h1, 0, "R6 set ipi1");
        slot_irq = '0;
        settle();
        settle();
        chk("R6 ipi1 holds after drop", 32'(cpu_irq), 32'b0010);
        access(1, 0, 'h804, 32'h0, 0, "R6 clear ipi1");
        settle();
        chk("R5 all low", 32'(cpu_irq), 32'd0);
        // R8 run enable
        access(1, 0, 'h214, 32'hB, 0, "R8 write run");
        chk("R8 cpu_run", 32'(cpu_run), 32'hB);
        access(0, 0, 'h214, 0, 32'hB, "R8 readback");
        // R9 power off
        access(1, 0, 'h208, 32'h5, 0, "R9 nonzero write");
        chk("R9 nonzero no effect", 32'(power_off), 32'd0);
        access(1, 0, 'h208, 32'h0, 0, "R9 zero write");
        chk("R9 power off set", 32'(power_off), 32'd1);
        access(1, 0, 'h208, 32'h7, 0, "R9 sticky write");
        chk("R9 power off sticky", 32'(power_off), 32'd1);
        // R11 unmapped
        access(0, 0, 'h100, 0, 32'd0, "R11 read unmapped");
        access(1, 0, 'h21C, 32'hFFFF_FFFF, 0, "R11 write unmapped");
        access(0, 0, 'h21C, 0, 32'd0, "R11 read after write");
        access(1, 0, 'h808, 32'hFFFF_FFFF, 0, "R11 write cpu gap");
        access(0, 0, 'h800, 0, 32'h4, "R11 route untouched");
        chk("R11 run untouched", 32'(cpu_run), 32'hB);
        // R2 request during ACK is not taken
        rd_q.push_back(1'b1); tag_q.push_back("R2 held request"); exp_q.push_back(32'h2);
        req_valid = 1'b1; req_write = 1'b0; req_cpu = 2'd1; req_addr = 16'h0218;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        chk("R2 retaken after ack", 32'(resp_ack), 32'd0);
        rd_q.push_back(1'b1); tag_q.push_back("R2 second take"); exp_q.push_back(32'h2);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        settle();
        chk("R2 queue drained", 32'(rd_q.size()), 32'd0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule